// File: doc/BRIEF.md
# Three-Level Sigma-Delta Bridge Modulator

This block turns a stream of signed audio samples into two one-bit drive signals, one for each half of a bridge-tied speaker load that has no output filter. Each drive bit means rail high (1) or rail low (0). Together the pair forms three differential states: positive, negative and zero. In the zero state both halves sit low, so no current is pushed through the speaker. At zero input the load therefore sees no pulses at all. The density of differential pulses grows with the magnitude of the input.

The loop works in sign-magnitude form. The magnitude of each sample feeds a chain of two saturating integrators with error feedback. A quantizer fires a pulse when the last integrator rises above half of full scale. The sign of the same sample steers that pulse onto the positive or negative half. A clock enable sets the modulator rate, and every enabled step consumes one sample. Driving the enable low clears the loop and parks both outputs low.

Top module: `tsd_mod`

## Requirements
- R1: The drive code is positive when drv_p=1 and drv_n=0, negative when drv_p=0 and drv_n=1, and zero when both are 0. Both outputs are 0 after reset.
- R2: drv_p and drv_n are never 1 at the same time.
- R3: A modulator step that takes a sample of value 0 produces the zero code.
- R4: A step with a positive sample never produces the negative code. A step with a negative sample never produces the positive code.
- R5: For a constant input with magnitude up to 0.75 of full scale (full scale = 2^(DW-1)), the mean of (drv_p − drv_n) over 4096 steps that start from a cleared loop is within 0.02 of din / 2^(DW-1).
- R6: When en is low at a clock edge, both outputs are 0 after that edge and both integrators are cleared. After en returns high, the same input produces the same pulse train as it does after reset.
- R7: The outputs change only on the clock edge at which ce and en are both high. On any other clock edge with en high, they hold their value.
- R8: For constant positive inputs, the pulse density is non-decreasing as the input magnitude rises.
- R9: An input that alternates between +4 and −4 LSB gives at most 8 pulses in 4096 steps, and no two of those pulses fall on adjacent steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Modulator-rate step enable |
| en | input | 1 | Run enable; low clears the loop and forces the outputs low |
| din | input | DW | Signed two's-complement audio sample |
| drv_p | output | 1 | Drive bit for the positive bridge half |
| drv_n | output | 1 | Drive bit for the negative bridge half |

## Verification
A pulse steered to the wrong half shows on the very next step as a code of the wrong polarity for the sample just applied. Every step is checked against the sign of its sample, so this kind of fault is caught at once. An integrator that is wrongly scaled, not saturated or fed back wrongly disturbs the pulse density. That error shows only as a drift in the 4096-step mean or as a break in the ordering of densities across inputs. A clear that fails to zero the state makes the pulse train after re-enable differ from the one after reset, usually within the first few dozen steps.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b10
  } lvl_e;

  localparam int LOOP_ORDER = 2;
endpackage

// File: rtl/tsd_split.sv
module tsd_split #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] smp,
  output logic        [DW-1:0] mag,
  output logic                 neg,
  output logic                 nz
);
  logic [DW-1:0] inv;

  always_comb begin
    inv = ~smp + 1'b1;
    neg = smp[DW-1];
    mag = neg ? inv : smp;
    nz  = |smp;
  end
endmodule

// File: rtl/tsd_integ.sv
module tsd_integ #(
  parameter int IW     = 21,
  parameter int FB_VAL = 32768
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 step,
  input  logic signed [IW-1:0] add_in,
  input  logic                 fb_on,
  output logic signed [IW-1:0] acc
);
  localparam logic signed [IW+1:0] HI  = {3'b000, {(IW-1){1'b1}}};
  localparam logic signed [IW+1:0] LO  = -HI;
  localparam logic signed [IW+1:0] FBX = (IW+2)'(FB_VAL);

  logic signed [IW+1:0] sum;
  logic signed [IW-1:0] nxt;

  always_comb begin
    sum = {{2{acc[IW-1]}}, acc} + {{2{add_in[IW-1]}}, add_in} - (fb_on ? FBX : '0);
    if (sum > HI)      nxt = HI[IW-1:0];
    else if (sum < LO) nxt = LO[IW-1:0];
    else               nxt = sum[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (step)   acc <= nxt;
  end

  AST_INT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0)); // R6

  AST_INT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (acc != {1'b1, {(IW-1){1'b0}}})); // R5
endmodule

// File: rtl/tsd_quant.sv
module tsd_quant
  import tsd_pkg::*;
#(
  parameter int IW = 21,
  parameter int DW = 16
) (
  input  logic signed [IW-1:0] acc,
  input  logic                 neg,
  input  logic                 nz,
  output lvl_e                 lvl,
  output logic                 pulse
);
  localparam logic signed [IW-1:0] HALF = IW'(2 ** (DW - 2));

  always_comb begin
    pulse = nz && (acc > HALF);
    if (!pulse)   lvl = LVL_ZERO;
    else if (neg) lvl = LVL_NEG;
    else          lvl = LVL_POS;
  end
endmodule

// File: rtl/tsd_mod.sv
module tsd_mod
  import tsd_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic                 drv_p,
  output logic                 drv_n
);
  localparam int FS = 2 ** (DW - 1);

  logic [DW-1:0]        mag;
  logic                 neg;
  logic                 nz;
  logic                 step;
  logic                 clr;
  logic                 pulse;
  lvl_e                 lvl;
  logic signed [IW-1:0] st_in [LOOP_ORDER];
  logic signed [IW-1:0] acc   [LOOP_ORDER];

  assign step = ce && en;
  assign clr  = !en;

  tsd_split #(.DW(DW)) u_split (
    .smp(din), .mag(mag), .neg(neg), .nz(nz)
  );

  for (genvar g = 0; g < LOOP_ORDER; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign st_in[g] = {{(IW-DW){1'b0}}, mag};
    end else begin : g_tail
      assign st_in[g] = acc[g-1];
    end
    tsd_integ #(.IW(IW), .FB_VAL(FS)) u_integ (
      .clk(clk), .rst(rst), .clr(clr), .step(step),
      .add_in(st_in[g]), .fb_on(pulse), .acc(acc[g])
    );
  end

  tsd_quant #(.IW(IW), .DW(DW)) u_quant (
    .acc(acc[LOOP_ORDER-1]), .neg(neg), .nz(nz), .lvl(lvl), .pulse(pulse)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      drv_p <= 1'b0;
      drv_n <= 1'b0;
    end else if (ce) begin
      drv_p <= (lvl == LVL_POS);
      drv_n <= (lvl == LVL_NEG);
    end
  end

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
    !(drv_p && drv_n)); // R2

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (step && din == '0) |=> (!drv_p && !drv_n)); // R3

  AST_POS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (step && !din[DW-1]) |=> !drv_n); // R4

  AST_NEG_ONLY: assert property (@(posedge clk) disable iff (rst)
    (step && din[DW-1]) |=> !drv_p); // R4

  AST_PARK_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!drv_p && !drv_n)); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !ce) |=> ($stable(drv_p) && $stable(drv_n))); // R7
endmodule

// File: tb/tsd_mod_test.sv
module tsd_mod_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam real FSR = 32768.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic en = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic drv_p, drv_n;

  tsd_mod #(.DW(DW), .IW(21)) uut (
    .clk(clk), .rst(rst), .ce(ce), .en(en), .din(din),
    .drv_p(drv_p), .drv_n(drv_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  logic fired = 1'b0;
  logic held = 1'b0;
  logic lastp = 1'b0;
  logic lastn = 1'b0;
  int sum_dir, pulses, adjacent;
  logic prev_pulse;
  logic [63:0] pat;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input real act, input real expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%f expected=%f at %0t", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    fired <= ce && en && !rst;
    held  <= en && !ce && !rst;
  end

  // Monitor: pops the sign expectation of each step and compares the drive code
  always @(negedge clk) begin
    if (fired) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected update", 1.0, 0.0);
      end else begin
        int sg;
        sg = exp_q.pop_front();
        check(!(drv_p && drv_n), "R2 both high", 1.0, 0.0);
        if (sg == 0)
          check(!drv_p && !drv_n, "R3 zero input pulse", real'(drv_p) - real'(drv_n), 0.0);
        else if (sg > 0)
          check(!drv_n, "R4 negative pulse on positive input", -1.0, 0.0);
        else
          check(!drv_p, "R4 positive pulse on negative input", 1.0, 0.0);
        sum_dir += int'(drv_p) - int'(drv_n);
        if (drv_p || drv_n) begin
          pulses++;
          if (prev_pulse) adjacent++;
        end
        prev_pulse = drv_p || drv_n;
        pat = {pat[62:0], drv_p};
      end
    end else if (held) begin
      check(drv_p == lastp && drv_n == lastn, "R7 output moved without ce",
            real'(drv_p) * 2.0 + real'(drv_n), real'(lastp) * 2.0 + real'(lastn));
    end
    lastp = drv_p;
    lastn = drv_n;
  end

  task automatic zero_stats();
    sum_dir = 0; pulses = 0; adjacent = 0; prev_pulse = 1'b0; pat = '0;
  endtask

  // Driver: one modulator step, expectation pushed to the scoreboard
  task automatic step(input logic signed [DW-1:0] v);
    @(negedge clk);
    din = v; ce = 1'b1; en = 1'b1;
    exp_q.push_back((v == 0) ? 0 : (v[DW-1] ? -1 : 1));
    @(negedge clk);
    ce = 1'b0;
  endtask

  task automatic clear_loop();
    @(negedge clk);
    en = 1'b0; ce = 1'b0;
    @(negedge clk);
    check(!drv_p && !drv_n, "R6 outputs low while disabled", real'(drv_p | drv_n), 0.0);
    en = 1'b1;
  endtask

  task automatic run_dc(input logic signed [DW-1:0] v, input int n);
    clear_loop();
    zero_stats();
    for (int i = 0; i < n; i++) step(v);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] pat_a;
    real dens, prev_dens, avg;
    int vals [6];
    bit seen;
    vals = '{1638, 3277, 6554, 13107, 19661, 24576};

    repeat (4) @(negedge clk);
    check(!drv_p && !drv_n, "R1 reset state low", real'(drv_p | drv_n), 0.0);
    rst = 1'b0;
    en = 1'b1;

    // R6: pattern straight after reset, then after a clear
    zero_stats();
    for (int i = 0; i < 64; i++) step(16'sd9830);
    @(negedge clk);
    pat_a = pat;
    check(pulses > 0, "R5 pulses present at 0.3 FS", real'(pulses), 19.0);
    run_dc(16'sd9830, 64);
    check(pat == pat_a, "R6 restart pattern matches reset pattern",
          real'(pat ^ pat_a), 0.0);

    // R3: silence
    run_dc(16'sd0, 512);
    check(pulses == 0, "R3 pulses with zero input", real'(pulses), 0.0);

    // R5 accuracy and R8 monotonic density
    prev_dens = 0.0;
    foreach (vals[k]) begin
      run_dc(vals[k][DW-1:0], 4096);
      avg  = real'(sum_dir) / 4096.0;
      dens = real'(pulses) / 4096.0;
      check((avg - real'(vals[k]) / FSR) <= 0.02 && (real'(vals[k]) / FSR - avg) <= 0.02,
            "R5 mean tracks DC input", avg, real'(vals[k]) / FSR);
      check(dens >= prev_dens, "R8 density non-decreasing", dens, prev_dens);
      prev_dens = dens;
    end

    run_dc(-16'sd9830, 4096);
    avg = real'(sum_dir) / 4096.0;
    check((avg + 0.3) <= 0.02 && (-0.3 - avg) <= 0.02,
          "R5 mean tracks negative DC input", avg, -9830.0 / FSR);

    // R9: small alternating noise
    clear_loop();
    zero_stats();
    for (int i = 0; i < 2048; i++) begin
      step(16'sd4);
      step(-16'sd4);
    end
    @(negedge clk);
    check(pulses <= 8, "R9 sparse pulses under noise", real'(pulses), 8.0);
    check(adjacent == 0, "R9 no adjacent pulses", real'(adjacent), 0.0);

    // R1 positive code, then R6 disable during a pulse
    clear_loop();
    seen = 1'b0;
    for (int i = 0; i < 32 && !seen; i++) begin
      step(16'sd24576);
      if (drv_p) seen = 1'b1;
    end
    check(seen && drv_p && !drv_n, "R1 positive code drv_p=1 drv_n=0",
          real'(drv_p) * 2.0 + real'(drv_n), 2.0);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!drv_p && !drv_n, "R6 disable forces outputs low",
          real'(drv_p) * 2.0 + real'(drv_n), 0.0);
    check(exp_q.size() == 0, "R7 every step produced one update", real'(exp_q.size()), 0.0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule